// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block steers the digital half of a successive-approximation converter. A pulse on `start_i` begins an N-bit binary search. The block presents a trial code to an external DAC, waits one clock for the DAC to settle, and then samples a single comparator bit. A set comparator bit means the DAC level lies above the analog input, so the bit under trial is cleared. Otherwise the bit is kept. The next lower bit then joins the code as the new trial bit.

The bit under trial is chosen by a one-hot pointer register. A load places the pointer at the most significant position, and each decision moves it one place toward the least significant position. A separate trial register holds the bits decided so far and drives the DAC. After the last decision the finished code is copied into a result register and `done_o` is raised for one clock. The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after the release is synchronised, `dac_code_o` and `result_o` are all zeros, and `busy_o` and `done_o` are 0.
- R2: A `start_i` that is sampled high while `busy_o` is 0 makes `busy_o` 1 in the following cycle. In that cycle `dac_code_o` equals the code with only its most significant bit set (half of full scale).
- R3: Each trial code stays on `dac_code_o` for two consecutive cycles. The comparator is sampled only at the clock edge that ends the second of these cycles.
- R4: When `cmp_hi_i` is 1 at a decision edge, the bit under trial is cleared. When it is 0, the bit stays set. If the bit is not the least significant one, the next lower bit is set in the following trial code, and the higher bits keep their decided values.
- R5: The trial pointer is one-hot during a conversion, starts at the most significant bit, and moves one position toward bit 0 after each decision.
- R6: The cycle after the least-significant decision has `done_o` = 1 and `busy_o` = 0. That edge falls 2·WIDTH clock edges after the edge that accepted the start, and `done_o` is 0 in the cycle after that.
- R7: `result_o` is loaded only at the edge that raises `done_o`. It then holds the final code, which is the largest code whose DAC level is not above the input, and it does not change at any other time.
- R8: `start_i` has no effect while `busy_o` is 1. The running conversion keeps its timing and its result.
- R9: An asynchronous reset during a conversion clears the pointer, the trial code, the result, `busy_o` and `done_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begin a conversion; taken only while idle |
| cmp_hi_i | input | 1 | Comparator: 1 when the DAC level is above the input |
| dac_code_o | output | WIDTH | Trial code driving the external DAC |
| result_o | output | WIDTH | Code of the last finished conversion |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
The hardest situation to reach from the ports is a start request that arrives in the middle of a search. It has to land on a decision edge that is not the last one, and the bench must then show that neither the timing nor the code was disturbed. The bench models the comparator as an exact compare against an input held at half-LSB resolution. It sweeps every such input level for a 4-bit build, which includes levels between codes and levels above full scale. On every fifth level it raises `start_i` on the decision edge of the second bit, and it checks that `done_o` still arrives at edge 2·WIDTH with the code that the input alone dictates. Each trial code in the sweep is also predicted in the bench from the bits decided so far.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_DECIDE = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/sar_phase_fsm.sv
module sar_phase_fsm
  import sar_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_bit_i,
  output logic load_o,
  output logic decide_o,
  output logic finish_o,
  output logic busy_o,
  output logic done_o
);
  sar_phase_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE:   if (start_i) state_d = PH_SETTLE;
      PH_SETTLE: state_d = PH_DECIDE;
      PH_DECIDE: state_d = last_bit_i ? PH_IDLE : PH_SETTLE;
      default:   state_d = PH_IDLE;
    endcase
  end

  assign load_o   = (state_q == PH_IDLE) && start_i;
  assign decide_o = (state_q == PH_DECIDE);
  assign finish_o = decide_o && last_bit_i;
  assign busy_o   = (state_q != PH_IDLE);
  assign done_d   = finish_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !finish_o) |=> busy_o);
endmodule

// File: rtl/sar_bit_pointer.sv
module sar_bit_pointer #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             busy_i,
  output logic [WIDTH-1:0] ptr_o,
  output logic             last_o
);
  localparam logic [WIDTH-1:0] TopBit = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  assign ptr_en = load_i || shift_i;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i)       ptr_d = TopBit;
    else if (shift_i) ptr_d = ptr_q >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o  = ptr_q;
  assign last_o = ptr_q[0];

  // R5
  ptr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> $onehot(ptr_q));

  // R5
  ptr_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ptr_q[WIDTH-1]);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             decide_i,
  input  logic             cmp_hi_i,
  input  logic [WIDTH-1:0] ptr_i,
  input  logic             last_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] data_next_o
);
  localparam logic [WIDTH-1:0] TopBit = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] data_q, data_d;
  logic [WIDTH-1:0] kept, next_trial;
  logic             data_en;

  assign data_en = load_i || decide_i;

  always_comb begin
    kept       = cmp_hi_i ? (data_q & ~ptr_i) : data_q;
    next_trial = last_i ? '0 : (ptr_i >> 1);
    data_d     = data_q;
    if (load_i)        data_d = TopBit;
    else if (decide_i) data_d = kept | next_trial;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign data_o      = data_q;
  assign data_next_o = kept;

  // R3
  trial_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decide_i |-> $stable(data_q));

  // R4
  trial_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && cmp_hi_i) |=> ((data_q & $past(ptr_i)) == '0));

  // R4
  trial_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && !cmp_hi_i) |=> ((data_q & $past(ptr_i)) != '0));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int WIDTH     = 8,
  parameter int SYNC_FLOPS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_hi_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [WIDTH-1:0] TopBit = {1'b1, {(WIDTH-1){1'b0}}};

  logic             rst_n;
  logic             load, decide, finish, last_bit, shift;
  logic [WIDTH-1:0] ptr, data_next;
  logic [WIDTH-1:0] result_q, result_d;

  sar_rst_sync #(.STAGES(SYNC_FLOPS)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  sar_phase_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .start_i   (start_i),
    .last_bit_i(last_bit),
    .load_o    (load),
    .decide_o  (decide),
    .finish_o  (finish),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  assign shift = decide && !last_bit;

  sar_bit_pointer #(.WIDTH(WIDTH)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (load),
    .shift_i(shift),
    .busy_i (busy_o),
    .ptr_o  (ptr),
    .last_o (last_bit)
  );

  sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (load),
    .decide_i   (decide),
    .cmp_hi_i   (cmp_hi_i),
    .ptr_i      (ptr),
    .last_i     (last_bit),
    .data_o     (dac_code_o),
    .data_next_o(data_next)
  );

  always_comb begin
    result_d = result_q;
    if (finish) result_d = data_next;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      result_q <= '0;
    else if (finish) result_q <= result_d;
  end

  assign result_o = result_q;

  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && dac_code_o == TopBit));

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  // R7
  result_match_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> (result_o == (dac_code_o & result_o)));
endmodule

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         cmp_hi_i;
  logic [W-1:0] dac_code_o, result_o;
  logic         busy_o, done_o;
  logic [W:0]   vin2 = '0;
  int           checks = 0;
  int           failures = 0;

  always #5 clk_i = ~clk_i;

  // ideal comparator: input held at half-LSB resolution
  assign cmp_hi_i = ({dac_code_o, 1'b0} > vin2);

  sar_seq_ctrl #(.WIDTH(W)) u_sar_seq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmp_hi_i(cmp_hi_i),
    .dac_code_o(dac_code_o), .result_o(result_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_conv(input int level, input bit poke);
    int decided = 0;
    int trial;
    int expect_code;
    vin2 = level[W:0];
    @(negedge clk_i); start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i); start_i = 1'b0;
    for (int s = 0; s < W; s++) begin
      trial = decided | (1 << (W - 1 - s));
      if (s == 0) chk("R2 first trial code", int'(dac_code_o), trial);
      else        chk("R4 next trial code", int'(dac_code_o), trial);
      chk("R2 busy during search", int'(busy_o), 1);
      chk("R6 done low mid search", int'(done_o), 0);
      @(posedge clk_i);
      @(negedge clk_i);
      chk("R3 trial code held", int'(dac_code_o), trial);
      if (poke && s == 1) start_i = 1'b1;
      @(posedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      if (trial * 2 <= level) decided = trial;
    end
    expect_code = (level / 2 > (1 << W) - 1) ? (1 << W) - 1 : level / 2;
    chk("R6 done after last decision", int'(done_o), 1);
    chk("R6 busy low with done", int'(busy_o), 0);
    chk("R7 result final code", int'(result_o), expect_code);
    chk("R4 search path matches input", decided, expect_code);
    if (poke) chk("R8 start while busy ignored", int'(result_o), expect_code);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R6 done single cycle", int'(done_o), 0);
    chk("R7 result held", int'(result_o), expect_code);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    chk("R1 dac in reset", int'(dac_code_o), 0);
    chk("R1 busy in reset", int'(busy_o), 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 dac after reset", int'(dac_code_o), 0);
    chk("R1 result after reset", int'(result_o), 0);
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 done after reset", int'(done_o), 0);

    for (int lv = 0; lv < (1 << (W + 1)); lv++) run_conv(lv, (lv % 5) == 0);

    // r9_ reset in the middle of a search
    vin2 = 5'd9;
    @(negedge clk_i); start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i); start_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    chk("R9 dac cleared", int'(dac_code_o), 0);
    chk("R9 result cleared", int'(result_o), 0);
    chk("R9 busy cleared", int'(busy_o), 0);
    chk("R9 done cleared", int'(done_o), 0);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    run_conv(7, 1'b0);
    run_conv(31, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule